// File: doc/BRIEF.md
# Partial-Scan Chain Test Sequencer

This block holds the two flip-flop groups of a partially scanned circuit and runs their test sequence. One group, the scan cells, is a serial chain of flip-flops with a multiplexer on D. The other group, the non-scan register, has no scan path and only ever loads functional data. Each group has its own clock enable, and the combinational logic of the circuit under test stays outside and talks to both groups through plain data ports. When no test is running the block is in normal mode: both enables are on and both groups load their functional inputs every cycle.

A pulse on `start` runs one complete test. The chain first gets a flush pattern. Then, for each requested vector, the chain state is shifted in and one functional capture clocks both groups. A final unload shifts the last captured state out. The unload of vector k is the same shift that loads vector k+1, so a separate unload happens only once, at the end. A cycle counter is visible at the ports, and `done` rises in the cycle that counter reaches the closed-form test length.

Top module: `pscan_seq`

## Requirements
- R1: While `rst_n` is low, `cyc_count` is 0, `done` is 0, `scan_mode` is 0 and every bit of `scan_q` and `core_q` is 0.
- R2: Outside a test (after reset or after `done`), `scan_mode` is 0, both `scan_clk_en` and `core_clk_en` are 1, and each clock loads `func_scan_d` into `scan_q` and `func_core_d` into `core_q`.
- R3: A `start` high at a clock edge outside a test latches `vec_count` as V and begins a flush of CHAIN_LEN+4 cycles. During the flush `scan_mode`=1, `scan_clk_en`=1 and `core_clk_en`=0. The chain's serial input is an internal pattern 0,0,1,1 that repeats from the first flush cycle, and `scan_in` is ignored.
- R4: In every shift cycle (`scan_mode`=1 and `scan_clk_en`=1), cell 0 takes the serial input, cell i takes cell i-1, and `scan_out` shows cell CHAIN_LEN-1. A word loaded MSB-first over CHAIN_LEN shifts ends up with its bit i in `scan_q[i]`.
- R5: Each vector is CHAIN_LEN shift cycles that take `scan_in`, followed by one capture cycle. In the capture cycle `scan_mode`=0 and both enables are 1, so `scan_q` loads `func_scan_d` and `core_q` loads `func_core_d`.
- R6: `core_q` holds its value in every cycle where `core_clk_en` is 0.
- R7: During the shift-in of vector k+1, `scan_out` presents the capture of vector k, bit CHAIN_LEN-1 first. During the first vector's shift-in, it presents the chain contents the flush left behind (0,0,1,1,...).
- R8: After the last capture, or straight after the flush when V=0, there are CHAIN_LEN unload shift cycles. The test then ends.
- R9: `cyc_count` is 0 in the first flush cycle and rises by one each cycle of the test. `done` is 0 during the test. `done` goes to 1 in the cycle `cyc_count` equals (V+2)*CHAIN_LEN+V+4, and it stays at 1 until the next `start`.
- R10: `start` is ignored while a test is running. The length of the test and its control outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test when idle or done |
| vec_count | input | VEC_W | Number of vectors, sampled with start |
| scan_in | input | 1 | Serial chain data from the tester |
| func_scan_d | input | CHAIN_LEN | Functional next state for the scan cells |
| func_core_d | input | CORE_W | Functional next state for the non-scan register |
| scan_out | output | 1 | Last chain cell |
| scan_q | output | CHAIN_LEN | Scan cell outputs |
| core_q | output | CORE_W | Non-scan register outputs |
| scan_mode | output | 1 | Test control: 1 selects the serial path into the chain |
| scan_clk_en | output | 1 | Clock enable of the scan group |
| core_clk_en | output | 1 | Clock enable of the non-scan group |
| done | output | 1 | Test complete |
| cyc_count | output | CYC_W | Clocks elapsed since the test began |

## Verification
The properties take for granted that the chain has at least two cells and that `cyc_count` never wraps during a test. An elaboration check enforces the second point for the largest `vec_count`. They also treat any `start` seen while `done` is high as the start of a new test, so the hold of `done` is checked only in cycles without `start`. The stimulus raises `start` for a single cycle at the beginning of each test. It raises it again only on purpose, in the middle of a flush, with a different `vec_count`, to show that this request changes nothing.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_FLUSH,
      PS_LOAD,
      PS_CAPT,
      PS_DRAIN,
      PS_DONE
   } pscan_state_e;
endpackage

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
   import pscan_pkg::*;
#(
   parameter int CHAIN_LEN = 8,
   parameter int VEC_W     = 4,
   parameter int CYC_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] vec_count,
   output logic             scan_mode,
   output logic             scan_clk_en,
   output logic             core_clk_en,
   output logic             flush_on,
   output logic             flush_bit,
   output logic             done,
   output logic [CYC_W-1:0] cyc_count
);
   localparam int FLUSH_LEN = CHAIN_LEN + 4;
   localparam int PH_W      = $clog2(FLUSH_LEN + 1);
   localparam logic [PH_W-1:0] PH_FLUSH_END = PH_W'(FLUSH_LEN - 1);
   localparam logic [PH_W-1:0] PH_SHIFT_END = PH_W'(CHAIN_LEN - 1);

   pscan_state_e     st_q;
   logic [PH_W-1:0]  ph_q;
   logic [VEC_W-1:0] vleft_q;
   logic [CYC_W-1:0] cyc_q;
   logic             running;

   assign running = (st_q != PS_IDLE) && (st_q != PS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         ph_q    <= '0;
         vleft_q <= '0;
         cyc_q   <= '0;
      end else begin
         if (running) cyc_q <= cyc_q + CYC_W'(1);
         unique case (st_q)
            PS_IDLE, PS_DONE: begin
               if (start) begin
                  st_q    <= PS_FLUSH;
                  ph_q    <= '0;
                  vleft_q <= vec_count;
                  cyc_q   <= '0;
               end
            end
            PS_FLUSH: begin
               if (ph_q == PH_FLUSH_END) begin
                  ph_q <= '0;
                  st_q <= (vleft_q != '0) ? PS_LOAD : PS_DRAIN;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            PS_LOAD: begin
               if (ph_q == PH_SHIFT_END) begin
                  ph_q <= '0;
                  st_q <= PS_CAPT;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            PS_CAPT: begin
               vleft_q <= vleft_q - VEC_W'(1);
               st_q    <= (vleft_q == VEC_W'(1)) ? PS_DRAIN : PS_LOAD;
            end
            PS_DRAIN: begin
               if (ph_q == PH_SHIFT_END) begin
                  ph_q <= '0;
                  st_q <= PS_DONE;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   always_comb begin
      scan_mode   = 1'b0;
      scan_clk_en = 1'b1;
      core_clk_en = 1'b1;
      unique case (st_q)
         PS_FLUSH, PS_LOAD, PS_DRAIN: begin
            scan_mode   = 1'b1;
            core_clk_en = 1'b0;
         end
         default: ;
      endcase
   end

   assign flush_on  = (st_q == PS_FLUSH);
   assign flush_bit = ph_q[1];
   assign done      = (st_q == PS_DONE);
   assign cyc_count = cyc_q;
endmodule

// File: rtl/pscan_chain.sv
module pscan_chain #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clk_en,
   input  logic                 sel_serial,
   input  logic                 ser_in,
   input  logic [CHAIN_LEN-1:0] func_d,
   output logic [CHAIN_LEN-1:0] q,
   output logic                 ser_out
);
   logic [CHAIN_LEN-1:0] shift_src;

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i == 0) begin : g_head
         assign shift_src[i] = ser_in;
      end else begin : g_body
         assign shift_src[i] = q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (clk_en)
            q[i] <= sel_serial ? shift_src[i] : func_d[i];
      end
   end

   assign ser_out = q[CHAIN_LEN-1];
endmodule

// File: rtl/pscan_hold_reg.sv
module pscan_hold_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clk_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clk_en)
         q <= d;
   end
endmodule

// File: rtl/pscan_seq.sv
module pscan_seq #(
   parameter int CHAIN_LEN = 8,
   parameter int CORE_W    = 4,
   parameter int VEC_W     = 4,
   parameter int CYC_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [VEC_W-1:0]     vec_count,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] func_scan_d,
   input  logic [CORE_W-1:0]    func_core_d,
   output logic                 scan_out,
   output logic [CHAIN_LEN-1:0] scan_q,
   output logic [CORE_W-1:0]    core_q,
   output logic                 scan_mode,
   output logic                 scan_clk_en,
   output logic                 core_clk_en,
   output logic                 done,
   output logic [CYC_W-1:0]     cyc_count
);
   localparam longint MAX_VEC   = (longint'(1) << VEC_W) - 1;
   localparam longint MAX_TOTAL = (MAX_VEC + 2) * CHAIN_LEN + MAX_VEC + 4;

   initial begin
      assert (CHAIN_LEN >= 2) else $error("pscan_seq: CHAIN_LEN must be at least 2");
      assert (CORE_W >= 1) else $error("pscan_seq: CORE_W must be at least 1");
      assert (VEC_W >= 1) else $error("pscan_seq: VEC_W must be at least 1");
      assert (MAX_TOTAL < (longint'(1) << CYC_W))
         else $error("pscan_seq: CYC_W too narrow for the longest test");
   end

   logic flush_on;
   logic flush_bit;
   logic chain_ser;

   pscan_ctrl #(
      .CHAIN_LEN(CHAIN_LEN),
      .VEC_W    (VEC_W),
      .CYC_W    (CYC_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vec_count  (vec_count),
      .scan_mode  (scan_mode),
      .scan_clk_en(scan_clk_en),
      .core_clk_en(core_clk_en),
      .flush_on   (flush_on),
      .flush_bit  (flush_bit),
      .done       (done),
      .cyc_count  (cyc_count)
   );

   assign chain_ser = flush_on ? flush_bit : scan_in;

   pscan_chain #(
      .CHAIN_LEN(CHAIN_LEN)
   ) chain_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (scan_clk_en),
      .sel_serial(scan_mode),
      .ser_in    (chain_ser),
      .func_d    (func_scan_d),
      .q         (scan_q),
      .ser_out   (scan_out)
   );

   pscan_hold_reg #(
      .W(CORE_W)
   ) core_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clk_en(core_clk_en),
      .d     (func_core_d),
      .q     (core_q)
   );
endmodule

// File: rtl/pscan_seq_chk.sv
module pscan_seq_chk #(
   parameter int CHAIN_LEN = 8,
   parameter int CORE_W    = 4,
   parameter int VEC_W     = 4,
   parameter int CYC_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic [VEC_W-1:0]     vec_count,
   input logic                 scan_in,
   input logic [CHAIN_LEN-1:0] func_scan_d,
   input logic [CORE_W-1:0]    func_core_d,
   input logic                 scan_out,
   input logic [CHAIN_LEN-1:0] scan_q,
   input logic [CORE_W-1:0]    core_q,
   input logic                 scan_mode,
   input logic                 scan_clk_en,
   input logic                 core_clk_en,
   input logic                 done,
   input logic [CYC_W-1:0]     cyc_count
);
   // R4: a shift moves every cell one place toward the output end
   a_r4_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_mode && scan_clk_en) |=>
         (scan_q[CHAIN_LEN-1:1] == $past(scan_q[CHAIN_LEN-2:0])));

   // R3: serial mode never clocks the non-scan group
   a_r3_scan_only: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mode |-> (scan_clk_en && !core_clk_en));

   // R5: functional cycles clock both groups
   a_r5_both_clocked: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_mode |-> (scan_clk_en && core_clk_en));

   // R6: the non-scan register holds while its enable is low
   a_r6_core_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |=> $stable(core_q));

   // R9: count rises by one per running cycle
   a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_count != '0 && !done) |=> (cyc_count == $past(cyc_count) + CYC_W'(1)));

   // R9: done stays until a new start
   a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(cyc_count)));

   // R10: a running test with a nonzero count does not restart
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_count != '0 && !done && start) |=> (cyc_count != '0));
endmodule

bind pscan_seq pscan_seq_chk #(
   .CHAIN_LEN(CHAIN_LEN),
   .CORE_W   (CORE_W),
   .VEC_W    (VEC_W),
   .CYC_W    (CYC_W)
) chk_i (.*);

// File: tb/pscan_seq_tb_top.sv
`timescale 1ns/1ps
module pscan_seq_tb_top;
   localparam int N  = 8;
   localparam int CW = 4;
   localparam int VW = 4;
   localparam int YW = 16;

   localparam logic [N-1:0]  PAT [6] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h96, 8'h01};
   localparam logic [N-1:0]  CAP [6] = '{8'h5A, 8'hC3, 8'h81, 8'h7E, 8'h18, 8'hFF};
   localparam logic [CW-1:0] NSD [6] = '{4'h3, 4'hC, 4'h5, 4'h9, 4'h6, 4'hE};
   localparam int RUN_V    [3] = '{3, 0, 2};
   localparam int RUN_BASE [3] = '{0, 0, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [VW-1:0] vec_count = '0;
   logic          scan_in = 1'b0;
   logic [N-1:0]  func_scan_d = '0;
   logic [CW-1:0] func_core_d = '0;
   logic          scan_out, scan_mode, scan_clk_en, core_clk_en, done;
   logic [N-1:0]  scan_q;
   logic [CW-1:0] core_q;
   logic [YW-1:0] cyc_count;

   int total = 0;
   int bad   = 0;
   int wd    = 0;

   always #2.5 clk = ~clk;

   pscan_seq #(.CHAIN_LEN(N), .CORE_W(CW), .VEC_W(VW), .CYC_W(YW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_count(vec_count),
      .scan_in(scan_in), .func_scan_d(func_scan_d), .func_core_d(func_core_d),
      .scan_out(scan_out), .scan_q(scan_q), .core_q(core_q),
      .scan_mode(scan_mode), .scan_clk_en(scan_clk_en), .core_clk_en(core_clk_en),
      .done(done), .cyc_count(cyc_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected<=20000", wd);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // one full test; called just after a falling edge
   task automatic run_seq(input int vn, input int base, input bit stray);
      logic [CW-1:0] core_exp;
      int len;
      len = (vn + 2) * N + vn + 4;
      core_exp = NSD[base] ^ 4'h5;
      start = 1'b1; vec_count = VW'(vn); func_core_d = core_exp;
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < N + 4; j++) begin
         check("R3 flush scan_mode", scan_mode, 1);
         check("R3 flush enables", {scan_clk_en, core_clk_en}, 2'b10);
         check("R9 count in flush", cyc_count, j);
         check("R6 core hold in flush", core_q, core_exp);
         scan_in = 1'b1;
         func_core_d = ~core_exp;
         if (stray && j == 2) begin start = 1'b1; vec_count = 4'd7; end
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      for (int v = 0; v < vn; v++) begin
         for (int j = 0; j < N; j++) begin
            if (v == 0) check("R7 flush content out", scan_out, (j >> 1) & 1);
            else        check("R7 prior capture out", scan_out, CAP[base+v-1][N-1-j]);
            check("R4 shift mode", {scan_mode, scan_clk_en, core_clk_en}, 3'b110);
            check("R6 core hold in shift", core_q, core_exp);
            check("R9 done low", done, 0);
            scan_in = PAT[base+v][N-1-j];
            @(negedge clk);
         end
         check("R4 loaded word", scan_q, PAT[base+v]);
         check("R5 capture controls", {scan_mode, scan_clk_en, core_clk_en}, 3'b011);
         func_scan_d = CAP[base+v];
         func_core_d = NSD[base+v];
         @(negedge clk);
         core_exp = NSD[base+v];
         check("R5 core capture", core_q, core_exp);
         func_core_d = ~core_exp;
      end
      for (int j = 0; j < N; j++) begin
         if (vn == 0) check("R8 unload flush", scan_out, (j >> 1) & 1);
         else         check("R8 unload capture", scan_out, CAP[base+vn-1][N-1-j]);
         check("R8 unload mode", {scan_mode, core_clk_en}, 2'b10);
         check("R9 done low in unload", done, 0);
         @(negedge clk);
      end
      check(stray ? "R10 length unchanged" : "R9 count at end", cyc_count, len);
      check("R9 done at end", done, 1);
      check("R6 core after unload", core_q, core_exp);
      check("R2 normal mode after done", {scan_mode, scan_clk_en, core_clk_en}, 3'b011);
      func_scan_d = '0; func_core_d = '0;
      @(negedge clk);
      check("R9 done held", done, 1);
      check("R9 count held", cyc_count, len);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset count", cyc_count, 0);
      check("R1 reset done", done, 0);
      check("R1 reset scan_mode", scan_mode, 0);
      check("R1 reset cells", {scan_q, core_q}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      func_scan_d = 8'h6B; func_core_d = 4'h2;
      @(negedge clk);
      check("R2 idle scan load", scan_q, 8'h6B);
      check("R2 idle core load", core_q, 4'h2);
      check("R2 idle enables", {scan_mode, scan_clk_en, core_clk_en}, 3'b011);
      func_scan_d = '0; func_core_d = '0;
      @(negedge clk);

      for (int r = 0; r < 3; r++) run_seq(RUN_V[r], RUN_BASE[r], 1'b0);

      // stray start during the flush
      run_seq(1, 5, 1'b1);

      // reset in the middle of a test
      start = 1'b1; vec_count = 4'd2;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check("R3 mid-run running", scan_mode, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset count", cyc_count, 0);
      check("R1 mid-run reset done", done, 0);
      check("R1 mid-run reset mode", scan_mode, 0);
      check("R1 mid-run reset cells", {scan_q, core_q}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule